// File: doc/BRIEF.md
# Reset, Startup and Sleep Sequencer

This block decides when the serial-bus interface of a peripheral may be used and when the peripheral may sleep. It watches an active-low reset pin and measures how long each low pulse lasts. A pulse of valid length is taken as a warm reset. A pulse that is too short has no effect. A pulse that is too long holds the interface down until the pin is released. After power-on and after every accepted reset, the interface stays unavailable for a startup interval. That interval is longer when a non-volatile write was pending when the pin went low.

Once the interface is up and no command is waiting, the block counts down a delay taken from a configuration input. It then waits for background idle work to drain, and only after that does it raise sleep enable. In sleep it ignores commands and returns to operation only when the bus logic reports a match on its own address. A command that arrives during the countdown or the drain stage cancels the wind-down.

All times are counted in ticks of a prescaler derived from the clock frequency and tick frequency parameters.

Top module: `pwrseq_top`

## Requirements
- R1: After the asynchronous reset, and for the power-on startup, `pwr_state` is 0, `if_ready` is 0 and `sleep_en` is 0.
- R2: The power-on startup lasts `START_T` ticks. After that, `if_ready` becomes 1 and `pwr_state` becomes 1 (active).
- R3: A reset-pin low pulse of `RST_MIN` to `RST_MAX` ticks, counted after a two-flop synchronizer, restarts the startup interval on release. `pwr_state` returns to 0 and `if_ready` to 0.
- R4: A reset-pin low pulse shorter than `RST_MIN` ticks is ignored. The outputs keep their values.
- R5: Once the pin has been low for more than `RST_MAX` ticks, the block is held unavailable (`pwr_state` 0) for as long as the pin stays low. A normal startup begins on release.
- R6: If `nvm_pend` was high when the synchronized pin fell, the startup after that reset lasts `START_NVM_T` ticks instead of `START_T`.
- R7: While active with `cmd_pend` low, the block loads `sleep_dly` and counts it down one per tick. During the countdown, `pwr_state` is 2.
- R8: When the countdown ends, the block stays in a drain stage (`pwr_state` 2) while `idle_busy` is high. It enters sleep (`pwr_state` 3, `sleep_en` 1) in the cycle after `idle_busy` and `cmd_pend` are both low.
- R9: `cmd_pend` high during the countdown or the drain stage returns the block to active (`pwr_state` 1) on the next clock.
- R10: In sleep, `cmd_pend` has no effect. An `addr_hit` pulse returns the block to active on the next clock.
- R11: With `sleep_dly` equal to 0 and no idle work pending, sleep is entered three clocks after `cmd_pend` falls.
- R12: The `pwr_state` code is 0 for unavailable (startup or held reset), 1 for active, 2 for winding down (countdown or drain) and 3 for asleep. `if_ready` is 1 in every state except unavailable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| nvm_pend | input | 1 | Non-volatile write pending |
| cmd_pend | input | 1 | Bus command waiting to be served |
| idle_busy | input | 1 | Background idle tasks still running |
| addr_hit | input | 1 | Pulse: own bus address detected |
| sleep_dly | input | DLY_W | Delay to sleep, in ticks |
| if_ready | output | 1 | Bus interface usable |
| pwr_state | output | 2 | Power state code (see R12) |
| sleep_en | output | 1 | Sleep permitted |

## Verification
Each control input reaches the outputs one clock later: a command, an address hit or the end of the drain stage changes `pwr_state` on the next rising edge. A reset-pin edge passes through two synchronizer flops before it is measured, so a release shows up on the outputs three clocks after the pin rises. Countdown lengths follow the tick phase, so the bench keeps a behavioural model that tracks the synchronizer delay and tick phase cycle by cycle. It compares all three outputs with that model at every falling edge. The directed checks wait well clear of each boundary before they sample a state code.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    PS_START,
    PS_HOLD,
    PS_RUN,
    PS_DELAY,
    PS_DRAIN,
    PS_SLEEP
  } pwr_st_e;

  localparam logic [1:0] CODE_DOWN   = 2'd0;
  localparam logic [1:0] CODE_ACTIVE = 2'd1;
  localparam logic [1:0] CODE_WIND   = 2'd2;
  localparam logic [1:0] CODE_SLEEP  = 2'd3;
endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV   = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int DIV_W = (DIV < 2) ? 1 : $clog2(DIV);

  generate
    if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == DIV_W'(DIV - 1)) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == DIV_W'(DIV - 1));

      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwrseq_rstq.sv
module pwrseq_rstq #(
  parameter int RST_MIN = 10,
  parameter int RST_MAX = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic nvm_pend,
  output logic warm_go,
  output logic hold,
  output logic nvm_long
);
  localparam int LOW_W = $clog2(RST_MAX + 2);

  logic             s1_q, s2_q;
  logic [LOW_W-1:0] low_q, low_d;
  logic             nvm_q, nvm_d;

  always_comb begin
    low_d = low_q;
    if (s2_q)                                      low_d = '0;
    else if (tick && (low_q <= LOW_W'(RST_MAX)))   low_d = low_q + 1'b1;
    nvm_d = s2_q ? nvm_pend : nvm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      low_q <= '0;
      nvm_q <= 1'b0;
    end else begin
      s1_q  <= pin_n;
      s2_q  <= s1_q;
      low_q <= low_d;
      nvm_q <= nvm_d;
    end
  end

  assign warm_go  = s2_q && (low_q >= LOW_W'(RST_MIN));
  assign hold     = !s2_q && (low_q > LOW_W'(RST_MAX));
  assign nvm_long = nvm_q;

  assert_low_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= LOW_W'(RST_MAX + 1));
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int START_T     = 15000,
  parameter int START_NVM_T = 20000,
  parameter int DLY_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             warm_go,
  input  logic             hold,
  input  logic             nvm_long,
  input  logic             cmd_pend,
  input  logic             idle_busy,
  input  logic             addr_hit,
  input  logic [DLY_W-1:0] sleep_dly,
  output logic             if_ready,
  output logic [1:0]       pwr_state,
  output logic             sleep_en
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int TMR_MAX = (START_NVM_T > DLY_MAX) ? START_NVM_T : DLY_MAX;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  pwr_st_e          st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (hold) begin
      st_d = PS_HOLD;
    end else if (warm_go) begin
      st_d  = PS_START;
      tmr_d = nvm_long ? TMR_W'(START_NVM_T) : TMR_W'(START_T);
    end else begin
      case (st_q)
        PS_START: begin
          if (tmr_q == '0) st_d  = PS_RUN;
          else if (tick)   tmr_d = tmr_q - 1'b1;
        end
        PS_HOLD: st_d = PS_HOLD;
        PS_RUN: begin
          if (!cmd_pend) begin
            st_d  = PS_DELAY;
            tmr_d = TMR_W'(sleep_dly);
          end
        end
        PS_DELAY: begin
          if (cmd_pend)         st_d  = PS_RUN;
          else if (tmr_q == '0) st_d  = PS_DRAIN;
          else if (tick)        tmr_d = tmr_q - 1'b1;
        end
        PS_DRAIN: begin
          if (cmd_pend)        st_d = PS_RUN;
          else if (!idle_busy) st_d = PS_SLEEP;
        end
        PS_SLEEP: begin
          if (addr_hit) st_d = PS_RUN;
        end
        default: st_d = PS_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_START;
      tmr_q <= TMR_W'(START_T);
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  always_comb begin
    case (st_q)
      PS_RUN:             pwr_state = CODE_ACTIVE;
      PS_DELAY, PS_DRAIN: pwr_state = CODE_WIND;
      PS_SLEEP:           pwr_state = CODE_SLEEP;
      default:            pwr_state = CODE_DOWN;
    endcase
  end

  assign if_ready = (st_q != PS_START) && (st_q != PS_HOLD);
  assign sleep_en = (st_q == PS_SLEEP);

  assert_hold_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pwr_state == CODE_DOWN));
  assert_warm_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_go && !hold) |=> !if_ready);
  assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_en) |-> (!$past(idle_busy) && !$past(cmd_pend)));
  assert_wake_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_en) |-> ($past(addr_hit) || $past(hold) || $past(warm_go)));
  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == CODE_WIND) && cmd_pend && !hold && !warm_go) |=> (pwr_state == CODE_ACTIVE));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TICK_HZ     = 1_000_000,
  parameter int RST_MIN     = 10,
  parameter int RST_MAX     = 2500,
  parameter int START_T     = 15000,
  parameter int START_NVM_T = 20000,
  parameter int DLY_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin_n,
  input  logic             nvm_pend,
  input  logic             cmd_pend,
  input  logic             idle_busy,
  input  logic             addr_hit,
  input  logic [DLY_W-1:0] sleep_dly,
  output logic             if_ready,
  output logic [1:0]       pwr_state,
  output logic             sleep_en
);
  logic tick, warm_go, hold, nvm_long;

  pwrseq_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwrseq_rstq #(.RST_MIN(RST_MIN), .RST_MAX(RST_MAX)) u_rstq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_n(rst_pin_n),
    .nvm_pend(nvm_pend), .warm_go(warm_go), .hold(hold), .nvm_long(nvm_long)
  );

  pwrseq_fsm #(.START_T(START_T), .START_NVM_T(START_NVM_T), .DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .warm_go(warm_go), .hold(hold),
    .nvm_long(nvm_long), .cmd_pend(cmd_pend), .idle_busy(idle_busy),
    .addr_hit(addr_hit), .sleep_dly(sleep_dly), .if_ready(if_ready),
    .pwr_state(pwr_state), .sleep_en(sleep_en)
  );
endmodule

// File: tb/pwrseq_top_bench.sv
module pwrseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_CLK  = 2_000_000;
  localparam int P_TICK = 1_000_000;
  localparam int DIV    = P_CLK / P_TICK;
  localparam int P_MIN  = 3;
  localparam int P_MAX  = 12;
  localparam int P_ST   = 30;
  localparam int P_NVM  = 45;
  localparam int P_DW   = 8;

  logic clk = 1'b0;
  logic rst_n, rst_pin_n, nvm_pend, cmd_pend, idle_busy, addr_hit;
  logic [P_DW-1:0] sleep_dly;
  logic if_ready, sleep_en;
  logic [1:0] pwr_state;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrseq_top #(
    .CLK_HZ(P_CLK), .TICK_HZ(P_TICK), .RST_MIN(P_MIN), .RST_MAX(P_MAX),
    .START_T(P_ST), .START_NVM_T(P_NVM), .DLY_W(P_DW)
  ) u_pwrseq_top (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .nvm_pend(nvm_pend),
    .cmd_pend(cmd_pend), .idle_busy(idle_busy), .addr_hit(addr_hit),
    .sleep_dly(sleep_dly), .if_ready(if_ready), .pwr_state(pwr_state),
    .sleep_en(sleep_en)
  );

  // behavioural reference: phase 0 startup, 1 held, 2 active, 3 countdown, 4 drain, 5 asleep
  int ph, remain, tphase, low_ticks, nvm_seen;
  bit pin_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; remain = P_ST; tphase = 0; low_ticks = 0; nvm_seen = 0;
      pin_hist = '{1'b1, 1'b1};
    end else begin
      bit is_tick, pin_now, go, hld;
      is_tick = (tphase == DIV - 1);
      pin_now = pin_hist[0];
      go  = pin_now && (low_ticks >= P_MIN);
      hld = !pin_now && (low_ticks > P_MAX);
      if (hld) ph = 1;
      else if (go) begin ph = 0; remain = nvm_seen ? P_NVM : P_ST; end
      else if (ph == 0) begin
        if (remain == 0) ph = 2; else if (is_tick) remain--;
      end else if (ph == 2) begin
        if (!cmd_pend) begin ph = 3; remain = int'(sleep_dly); end
      end else if (ph == 3) begin
        if (cmd_pend) ph = 2; else if (remain == 0) ph = 4; else if (is_tick) remain--;
      end else if (ph == 4) begin
        if (cmd_pend) ph = 2; else if (!idle_busy) ph = 5;
      end else if (ph == 5) begin
        if (addr_hit) ph = 2;
      end
      if (pin_now) begin low_ticks = 0; nvm_seen = nvm_pend; end
      else if (is_tick && low_ticks <= P_MAX) low_ticks++;
      tphase = (tphase + 1) % DIV;
      void'(pin_hist.pop_front());
      pin_hist.push_back(rst_pin_n);
    end
  end

  always @(negedge clk) begin
    int e_ps;
    e_ps = (ph <= 1) ? 0 : (ph == 2) ? 1 : (ph <= 4) ? 2 : 3;
    n_cmp++;
    if (int'(pwr_state) != e_ps || if_ready != (ph >= 2) || sleep_en != (ph == 5)) begin
      n_bad++;
      $display("FAIL %s model: ps=%0d rdy=%0d slp=%0d expected ps=%0d rdy=%0d slp=%0d",
               cur_req, pwr_state, if_ready, sleep_en, e_ps, (ph >= 2), (ph == 5));
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s directed: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin(input int n);
    rst_pin_n = 1'b0; cyc(n); rst_pin_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_pin_n = 1'b1; nvm_pend = 1'b0; cmd_pend = 1'b1;
    idle_busy = 1'b0; addr_hit = 1'b0; sleep_dly = 8'd5;
    cyc(3);
    chk("R1", int'(pwr_state), 0);
    chk("R1", int'(if_ready), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", int'(sleep_en), 0);
    cur_req = "R2"; cyc(70);
    chk("R2", int'(if_ready), 1);
    chk("R12", int'(pwr_state), 1);
    // R7 countdown then R8 drain
    cur_req = "R7"; idle_busy = 1'b1; cmd_pend = 1'b0; cyc(4);
    chk("R7", int'(pwr_state), 2);
    cur_req = "R8"; cyc(20);
    chk("R8", int'(pwr_state), 2);
    chk("R8", int'(sleep_en), 0);
    idle_busy = 1'b0; cyc(3);
    chk("R8", int'(sleep_en), 1);
    chk("R12", int'(pwr_state), 3);
    // R10 commands ignored in sleep, address wakes
    cur_req = "R10"; cmd_pend = 1'b1; cyc(6);
    chk("R10", int'(pwr_state), 3);
    addr_hit = 1'b1; cyc(1); addr_hit = 1'b0; cyc(1);
    chk("R10", int'(pwr_state), 1);
    // R9 cancel during countdown and drain
    cur_req = "R9"; cmd_pend = 1'b0; cyc(4);
    chk("R9", int'(pwr_state), 2);
    cmd_pend = 1'b1; cyc(2);
    chk("R9", int'(pwr_state), 1);
    idle_busy = 1'b1; cmd_pend = 1'b0; cyc(20);
    chk("R9", int'(pwr_state), 2);
    cmd_pend = 1'b1; cyc(2);
    chk("R9", int'(pwr_state), 1);
    idle_busy = 1'b0;
    // R4 short pulse
    cur_req = "R4"; pulse_pin(4); cyc(10);
    chk("R4", int'(pwr_state), 1);
    chk("R4", int'(if_ready), 1);
    // R3 valid pulse
    cur_req = "R3"; pulse_pin(12); cyc(4);
    chk("R3", int'(pwr_state), 0);
    chk("R3", int'(if_ready), 0);
    cyc(70);
    chk("R3", int'(pwr_state), 1);
    // R6 extended startup
    cur_req = "R6"; nvm_pend = 1'b1; cyc(4); pulse_pin(12); cyc(4); nvm_pend = 1'b0;
    cyc(66);
    chk("R6", int'(pwr_state), 0);
    cyc(40);
    chk("R6", int'(pwr_state), 1);
    // R5 held reset
    cur_req = "R5"; rst_pin_n = 1'b0; cyc(34);
    chk("R5", int'(pwr_state), 0);
    chk("R5", int'(if_ready), 0);
    cyc(20);
    chk("R5", int'(pwr_state), 0);
    rst_pin_n = 1'b1; cyc(4);
    chk("R5", int'(pwr_state), 0);
    cyc(70);
    chk("R5", int'(pwr_state), 1);
    // R11 zero delay
    cur_req = "R11"; sleep_dly = 8'd0; cmd_pend = 1'b0; cyc(2);
    chk("R11", int'(sleep_en), 0);
    cyc(1);
    chk("R11", int'(sleep_en), 1);
    addr_hit = 1'b1; cmd_pend = 1'b1; cyc(1); addr_hit = 1'b0; cyc(2);
    chk("R11", int'(pwr_state), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule